// File: doc/BRIEF.md
# Predicated Packed SIMD Lane Adder

This block adds two 128-bit packed vectors element by element and registers the result. A two-bit size code splits the vectors into sixteen 8-bit, eight 16-bit or four 32-bit elements. Element 0 sits in the least significant bits. Each element wraps on its own, so no carry passes into its neighbour.

A 16-bit predicate has one bit per byte of the vector. It decides which elements receive the sum. An element that is not selected either keeps the matching element of a third input vector (merge mode) or is cleared to zero (zero mode). With an all-ones predicate the block is a plain packed adder.

The result is captured one clock after a valid strobe and stays in place until the next strobe. A one-cycle delayed copy of the strobe marks when the result is new.

Top module: `simd_pred_adder`

## Requirements
- R1: `lane_size` selects the element width: 0 gives 8-bit, 1 gives 16-bit, and 2 or 3 give 32-bit elements.
- R2: Element k of a vector with width w occupies bits [k*w+w-1 : k*w], so element 0 is the least significant.
- R3: Each active element equals (src_a + src_b) modulo 2^w. No carry crosses from one element into the next.
- R4: An element is active when the predicate bit of its lowest byte is 1. That is bit k*w/8 for element k: bits 0, 4, 8 and 12 for 32-bit elements, the even bits for 16-bit elements, and every bit for 8-bit elements.
- R5: With `zero_mode` = 0, an inactive element takes the matching element of `inactive_v`. For example, 32-bit elements with predicate 0xF00F update elements 0 and 3 only.
- R6: With `zero_mode` = 1, an inactive element is written as zero.
- R7: Predicate bits that are not the lowest byte of any element have no effect on the result.
- R8: `result` takes the new value at the first rising edge on which `in_valid` is high. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high.
- R9: While `in_valid` is low, `result` keeps its value, whatever the data inputs do.
- R10: While `rst_n` is low, `result` is all zeros and `out_valid` is 0.
- R11: With predicate 0xFFFF, the result is the unpredicated element-wise sum in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that captures a new result |
| lane_size | input | 2 | Element width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| zero_mode | input | 1 | 1 = clear inactive elements, 0 = merge them from `inactive_v` |
| pred | input | 16 | Predicate, one bit per byte |
| src_a | input | 128 | First addend vector |
| src_b | input | 128 | Second addend vector |
| inactive_v | input | 128 | Source for inactive elements in merge mode |
| out_valid | output | 1 | High for one cycle after a capture |
| result | output | 128 | Registered predicated sum |

## Verification
A carry segment that is cut in the wrong place shows up in the result register one cycle after the strobe, in the byte just above an element boundary. Byte vectors of 0xFF added to 0x01 make that byte nonzero where it should be zero.

A byte enable that reads the wrong predicate bit puts a sum where an inactive value belongs, or the reverse. This appears in the same cycle, and only for element widths whose sampled bits differ from the pattern applied. The sweep therefore pairs every width with predicates whose sampled and unsampled bits disagree.

A register that fails to hold shows up in the cycle after a strobe-free edge.

// File: rtl/spa_pkg.sv
package spa_pkg;
    localparam int VEC_W  = 128;
    localparam int NBYTES = VEC_W / 8;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_ALT = 2'd3
    } lane_size_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } spa_state_t;
endpackage

// File: rtl/spa_byte_enable.sv
module spa_byte_enable #(
    parameter int NB = 16
) (
    input  logic [1:0]    size,
    input  logic [NB-1:0] pred,
    output logic [NB-1:0] byte_en
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int BASE16 = i - (i % 2);
        localparam int BASE32 = i - (i % 4);
        always_comb begin
            unique case (size)
                2'd0:    byte_en[i] = pred[i];
                2'd1:    byte_en[i] = pred[BASE16];
                default: byte_en[i] = pred[BASE32];
            endcase
        end
    end
endmodule

// File: rtl/spa_seg_adder.sv
module spa_seg_adder #(
    parameter int NB = 16
) (
    input  logic [1:0]      size,
    input  logic [NB*8-1:0] a,
    input  logic [NB*8-1:0] b,
    output logic [NB*8-1:0] sum
);
    logic [NB-1:0] cout;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam bit EDGE16 = (i % 2) == 0;
        localparam bit EDGE32 = (i % 4) == 0;
        logic       seg_start;
        logic       cin;
        logic [8:0] part;

        always_comb begin
            unique case (size)
                2'd0:    seg_start = 1'b1;
                2'd1:    seg_start = EDGE16;
                default: seg_start = EDGE32;
            endcase
        end

        if (i == 0) begin : g_first
            assign cin = 1'b0;
        end else begin : g_rest
            assign cin = seg_start ? 1'b0 : cout[i-1];
        end

        assign part          = {1'b0, a[i*8 +: 8]} + {1'b0, b[i*8 +: 8]} + {8'd0, cin};
        assign sum[i*8 +: 8] = part[7:0];
        assign cout[i]       = part[8];
    end
endmodule

// File: rtl/simd_pred_adder.sv
module simd_pred_adder
    import spa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        lane_size,
    input  logic              zero_mode,
    input  logic [NBYTES-1:0] pred,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  inactive_v,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    logic [VEC_W-1:0]  raw_sum;
    logic [NBYTES-1:0] byte_en;
    logic [VEC_W-1:0]  picked;
    spa_state_t        st_d, st_q;

    spa_seg_adder #(.NB(NBYTES)) adder_i (
        .size (lane_size),
        .a    (src_a),
        .b    (src_b),
        .sum  (raw_sum)
    );

    spa_byte_enable #(.NB(NBYTES)) enable_i (
        .size    (lane_size),
        .pred    (pred),
        .byte_en (byte_en)
    );

    for (genvar i = 0; i < NBYTES; i++) begin : g_pick
        always_comb begin
            if (byte_en[i])
                picked[i*8 +: 8] = raw_sum[i*8 +: 8];
            else if (zero_mode)
                picked[i*8 +: 8] = 8'd0;
            else
                picked[i*8 +: 8] = inactive_v[i*8 +: 8];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.res = picked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/spa_checker.sv
module spa_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         zero_mode,
    input logic [15:0]  pred,
    input logic [127:0] src_a,
    input logic [127:0] src_b,
    input logic [127:0] inactive_v,
    input logic         out_valid,
    input logic [127:0] result
);
    // R8
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R3
    low_byte_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[0]) |=> result[7:0] == $past(src_a[7:0] + src_b[7:0]));

    // R5
    low_byte_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred[0] && !zero_mode) |=> result[7:0] == $past(inactive_v[7:0]));

    // R6
    low_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred[0] && zero_mode) |=> result[7:0] == 8'd0);
endmodule

bind simd_pred_adder spa_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .zero_mode  (zero_mode),
    .pred       (pred),
    .src_a      (src_a),
    .src_b      (src_b),
    .inactive_v (inactive_v),
    .out_valid  (out_valid),
    .result     (result)
);

// File: tb/simd_pred_adder_tb_top.sv
module simd_pred_adder_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_size = 2'd0;
    logic         zero_mode = 1'b0;
    logic [15:0]  pred = 16'd0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] inactive_v = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    simd_pred_adder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .lane_size  (lane_size),
        .zero_mode  (zero_mode),
        .pred       (pred),
        .src_a      (src_a),
        .src_b      (src_b),
        .inactive_v (inactive_v),
        .out_valid  (out_valid),
        .result     (result)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] inact, input logic [15:0] p,
                                           input logic [1:0] sz, input logic zm);
        int lb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        int w  = lb * 8;
        logic [127:0] m = (128'h1 << w) - 128'h1;
        logic [127:0] r = '0;
        for (int l = 0; l < 16 / lb; l++) begin
            logic [127:0] ea = (a >> (l * w)) & m;
            logic [127:0] eb = (b >> (l * w)) & m;
            logic [127:0] ei = (inact >> (l * w)) & m;
            logic [127:0] ev;
            if (p[l * lb]) ev = (ea + eb) & m;
            else if (zm)   ev = '0;
            else           ev = ei;
            r |= ev << (l * w);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] sz, input logic zm, input logic [15:0] p,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] inact, input string tag);
        logic [127:0] exp;
        @(negedge clk);
        lane_size = sz; zero_mode = zm; pred = p;
        src_a = a; src_b = b; inactive_v = inact; in_valid = 1'b1;
        exp = model(a, b, inact, p, sz, zm);
        @(negedge clk);
        in_valid = 1'b0;
        check(result === exp, tag, result, exp);
        check(out_valid === 1'b1, "R8 out_valid after strobe", {127'd0, out_valid}, 128'd1);
    endtask

    logic [15:0]  preds [8];
    logic [127:0] avs   [3];
    logic [127:0] bvs   [3];

    initial begin
        preds[0] = 16'hFFFF; preds[1] = 16'h0000; preds[2] = 16'hF00F; preds[3] = 16'h1111;
        preds[4] = 16'h300C; preds[5] = 16'h5555; preds[6] = 16'hEEEE; preds[7] = 16'h0102;
        avs[0] = {16{8'hFF}};                          bvs[0] = {16{8'h01}};
        avs[1] = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0; bvs[1] = 128'h80FF7F01_FFFF0001_7FFFFFFF_00FF80FF;
        avs[2] = 128'h11111111_22222222_33333333_44444444; bvs[2] = 128'hDEADBEEF_CAFEF00D_FFFFFFFF_00000001;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(result === '0, "R10 result in reset", result, '0);
        check(out_valid === 1'b0, "R10 out_valid in reset", {127'd0, out_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R8 no strobe no out_valid", {127'd0, out_valid}, '0);

        // R5 example: 32-bit, 0xF00F updates elements 0 and 3 only
        apply(2'd2, 1'b0, 16'hF00F,
              128'h44444444_33333333_22222222_11111111,
              128'h44444444_33333333_22222222_11111111,
              {4{32'h55555555}}, "R5 R4 example 0xF00F");
        check(result === 128'h88888888_55555555_55555555_22222222, "R5 R2 literal",
              result, 128'h88888888_55555555_55555555_22222222);

        // Sweep: R1 R2 R3 R4 R5 R6 R7 R11
        for (int s = 0; s < 4; s++) begin
            for (int zm = 0; zm < 2; zm++) begin
                for (int pi = 0; pi < 8; pi++) begin
                    for (int di = 0; di < 3; di++) begin
                        string tag;
                        if (pi == 0)      tag = "R11 all-ones plain add";
                        else if (pi >= 6) tag = "R7 unsampled bits ignored";
                        else if (di == 0) tag = "R3 no carry across elements";
                        else if (zm == 1) tag = "R6 zeroing";
                        else              tag = "R5 merging";
                        tag = $sformatf("%s R1 size=%0d R4 pred=%h", tag, s, preds[pi]);
                        apply(2'(s), 1'(zm), preds[pi], avs[di], bvs[di], ~avs[di], tag);
                    end
                end
            end
        end

        // R9: result holds while in_valid low, data changing
        for (int k = 0; k < 4; k++) begin
            logic [127:0] held;
            apply(2'(k), 1'b0, 16'hFFFF, avs[k % 3], bvs[k % 3], '0, "R11 pre-hold load");
            held = result;
            @(negedge clk);
            src_a = ~src_a; src_b = {16{8'h5A}}; pred = ~pred; zero_mode = 1'b1;
            @(negedge clk);
            check(result === held, "R9 hold without strobe", result, held);
            check(out_valid === 1'b0, "R8 out_valid drops", {127'd0, out_valid}, '0);
        end

        // R8: back-to-back strobes
        @(negedge clk);
        lane_size = 2'd0; zero_mode = 1'b0; pred = 16'hFFFF;
        src_a = avs[1]; src_b = bvs[1]; in_valid = 1'b1;
        @(negedge clk);
        check(result === model(avs[1], bvs[1], '0, 16'hFFFF, 2'd0, 1'b0), "R8 first of pair",
              result, model(avs[1], bvs[1], '0, 16'hFFFF, 2'd0, 1'b0));
        src_a = avs[2]; src_b = bvs[2];
        @(negedge clk);
        in_valid = 1'b0;
        check(result === model(avs[2], bvs[2], '0, 16'hFFFF, 2'd0, 1'b0), "R8 second of pair",
              result, model(avs[2], bvs[2], '0, 16'hFFFF, 2'd0, 1'b0));
        check(out_valid === 1'b1, "R8 out_valid stays high", {127'd0, out_valid}, 128'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule